// File: doc/BRIEF.md
# Link Width Fallback Controller

This block holds the lane width that a serial link port should train at and narrows it on its own when training keeps failing, so that the system stays up at lower bandwidth without any software action. Each training attempt reports its outcome as a one-cycle success or failure pulse. A run of failures at one width moves the port down one step on a fixed ladder: eight lanes, then four, then two, then one. Each step issues a one-cycle retrain request at the new width.

The single-lane width is reserved for special cases, so it is reachable only while a configuration enable is set. When a persistent failure occurs at the narrowest width allowed, the block raises a sticky link-down flag and stops asking for retraining. A synchronous reset or a re-enable request restarts the block at the configured maximum width.

Top module: `link_width_fallback`

## Requirements
- R1: Widths are one-hot on 4 bits: bit3 = x8, bit2 = x4, bit1 = x2, bit0 = x1. In the cycle after a reset or re-enable edge, `width_o` equals the configured maximum, `retrain_o` = 0 and `link_down_o` = 0. The configured maximum is the highest set bit of `cfg_max_width`. An all-zero value selects x8. A value of x1 while `cfg_x1_en` = 0 selects x2.
- R2: Fewer than FAIL_LIMIT consecutive failed attempts (default 3) leave `width_o` unchanged and produce no retrain request.
- R3: A success pulse clears the consecutive failure count. A cycle carrying both a success and a failure pulse counts as a success.
- R4: The FAIL_LIMIT-th consecutive failure at x8 or x4 narrows the width by one step, to x4 or x2. The new width and a one-cycle `retrain_o` pulse are present in the cycle after the edge that samples that failure. The count restarts at zero.
- R5: A persistent failure at x2 steps down to x1 only when `cfg_x1_en` = 1. When `cfg_x1_en` = 0, x2 is the narrowest width.
- R6: A persistent failure at the narrowest allowed width sets `link_down_o` in the next cycle and keeps the width. `link_down_o` stays set until reset or re-enable. While it is set, no retrain request is issued and success and failure pulses have no effect.
- R7: A re-enable request takes priority over any success or failure pulse in the same cycle.
- R8: `width_o` always has exactly one bit set outside reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_max_width | input | 4 | Configured maximum width, one-hot |
| cfg_x1_en | input | 1 | Allows the single-lane width |
| train_ok | input | 1 | Training attempt succeeded (pulse) |
| train_fail | input | 1 | Training attempt failed (pulse) |
| reenable | input | 1 | Restart at the configured maximum |
| width_o | output | 4 | Current target width, one-hot |
| retrain_o | output | 1 | One-cycle retrain request after a step |
| link_down_o | output | 1 | Sticky fatal link-down flag |

## Verification
All three outputs are registered, so every result is due in the cycle after the clock edge that samples its stimulus. The bench drives inputs on the falling edge and checks the outputs on the following falling edge. It checks once more a cycle later to confirm that the retrain pulse has ended. The bench sweeps all 16 `cfg_max_width` codes against both x1 enable settings. For each combination it uses its own level arithmetic to predict the full ladder through to link-down.

// File: rtl/lwf_pkg.sv
package lwf_pkg;
  localparam int WIDTH_BITS = 4;
  typedef logic [WIDTH_BITS-1:0] lane_width_t;

  // Highest set bit of the configured width; none -> widest; x1 demoted when not allowed.
  function automatic lane_width_t lwf_max_width(input lane_width_t cfg, input logic x1_en);
    lane_width_t res;
    res = '0;
    for (int i = 0; i < WIDTH_BITS; i++) begin
      if (cfg[i]) res = lane_width_t'(1) << i;
    end
    if (res == '0) res = lane_width_t'(1) << (WIDTH_BITS-1);
    if (res[0] && !x1_en) res = lane_width_t'(2);
    return res;
  endfunction

  function automatic lane_width_t lwf_narrower(input lane_width_t w);
    return w >> 1;
  endfunction

  function automatic logic lwf_can_narrow(input lane_width_t w, input logic x1_en);
    return (|w[WIDTH_BITS-1:2]) | (w[1] & x1_en);
  endfunction
endpackage

// File: rtl/lwf_fail_counter.sv
module lwf_fail_counter #(
  parameter int FAIL_LIMIT = 3,
  localparam int CNT_W = (FAIL_LIMIT < 2) ? 1 : $clog2(FAIL_LIMIT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             hold,
  input  logic             ok,
  input  logic             fail,
  output logic             persist_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_last;
  logic             fail_evt;

  assign at_last   = (cnt_q == CNT_W'(FAIL_LIMIT-1));
  assign fail_evt  = fail & ~ok & ~hold & ~clear;
  assign persist_o = fail_evt & at_last;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt_q <= '0;
    end else if (!hold) begin
      if (ok)            cnt_q <= '0;
      else if (persist_o) cnt_q <= '0;
      else if (fail_evt)  cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assert_cnt_below_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < FAIL_LIMIT);

  assert_ok_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && !hold) |=> (cnt_q == '0));
endmodule

// File: rtl/lwf_width_ladder.sv
module lwf_width_ladder
  import lwf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  lane_width_t cfg_max,
  input  logic        x1_en,
  input  logic        persist,
  output lane_width_t width_o,
  output logic        retrain_o,
  output logic        down_o,
  output logic        step_evt_o
);
  lane_width_t width_q;
  logic        retrain_q;
  logic        down_q;
  logic        can_step;
  logic        fatal_evt;

  assign can_step   = lwf_can_narrow(width_q, x1_en);
  assign step_evt_o = persist & ~down_q & can_step;
  assign fatal_evt  = persist & ~down_q & ~can_step;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      width_q   <= lwf_max_width(cfg_max, x1_en);
      retrain_q <= 1'b0;
      down_q    <= 1'b0;
    end else begin
      retrain_q <= step_evt_o;
      if (step_evt_o) width_q <= lwf_narrower(width_q);
      if (fatal_evt)  down_q  <= 1'b1;
    end
  end

  assign width_o   = width_q;
  assign retrain_o = retrain_q;
  assign down_o    = down_q;

  assert_width_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(width_q));

  assert_step_one_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    retrain_q |-> (width_q == ($past(width_q) >> 1)));

  assert_x1_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (retrain_q && width_q[0]) |-> $past(x1_en));

  assert_down_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (down_q && !clear) |=> down_q);

  assert_no_retrain_when_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    down_q |-> !retrain_q);
endmodule

// File: rtl/link_width_fallback.sv
module link_width_fallback
  import lwf_pkg::*;
#(
  parameter int FAIL_LIMIT = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] cfg_max_width,
  input  logic       cfg_x1_en,
  input  logic       train_ok,
  input  logic       train_fail,
  input  logic       reenable,
  output logic [3:0] width_o,
  output logic       retrain_o,
  output logic       link_down_o
);
  localparam int CNT_W = (FAIL_LIMIT < 2) ? 1 : $clog2(FAIL_LIMIT);

  logic             persist_evt;
  logic             step_evt;
  logic             down_w;
  logic [CNT_W-1:0] fail_cnt;

  lwf_fail_counter #(.FAIL_LIMIT(FAIL_LIMIT)) cnt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (reenable),
    .hold      (down_w),
    .ok        (train_ok),
    .fail      (train_fail),
    .persist_o (persist_evt),
    .cnt_o     (fail_cnt)
  );

  lwf_width_ladder ladder_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (reenable),
    .cfg_max    (cfg_max_width),
    .x1_en      (cfg_x1_en),
    .persist    (persist_evt),
    .width_o    (width_o),
    .retrain_o  (retrain_o),
    .down_o     (down_w),
    .step_evt_o (step_evt)
  );

  assign link_down_o = down_w;

  assert_reenable_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reenable |=> (!retrain_o && !link_down_o && fail_cnt == '0));

  assert_step_pulses_retrain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> retrain_o);
endmodule

// File: tb/link_width_fallback_tb_top.sv
module link_width_fallback_tb_top;
  localparam int LIMIT = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cfg_max_width = 4'b1000;
  logic       cfg_x1_en = 1'b1;
  logic       train_ok = 1'b0;
  logic       train_fail = 1'b0;
  logic       reenable = 1'b0;
  logic [3:0] width_o;
  logic       retrain_o;
  logic       link_down_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  link_width_fallback #(.FAIL_LIMIT(LIMIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_max_width(cfg_max_width), .cfg_x1_en(cfg_x1_en),
    .train_ok(train_ok), .train_fail(train_fail), .reenable(reenable),
    .width_o(width_o), .retrain_o(retrain_o), .link_down_o(link_down_o)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int level_of_cfg(input logic [3:0] cfg, input logic x1);
    int lvl;
    lvl = -1;
    if (cfg[3]) lvl = 3;
    else if (cfg[2]) lvl = 2;
    else if (cfg[1]) lvl = 1;
    else if (cfg[0]) lvl = 0;
    if (lvl < 0) lvl = 3;
    if (lvl == 0 && !x1) lvl = 1;
    return lvl;
  endfunction

  function automatic int code_of(input int lvl);
    return 1 << lvl;
  endfunction

  task automatic pulse(input logic ok, input logic fl);
    train_ok = ok;
    train_fail = fl;
    tick();
    train_ok = 1'b0;
    train_fail = 1'b0;
  endtask

  task automatic do_reenable();
    reenable = 1'b1;
    tick();
    reenable = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lvl, minl, cnt;
    bit down;
    @(negedge clk);
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk("R1", "reset width", int'(width_o), 8);
    chk("R1", "reset retrain", int'(retrain_o), 0);
    chk("R1", "reset link_down", int'(link_down_o), 0);

    // Full sweep: every config code with both x1 settings, driven to link-down.
    for (int x = 0; x < 2; x++) begin
      for (int c = 0; c < 16; c++) begin
        cfg_max_width = 4'(c);
        cfg_x1_en = x[0];
        do_reenable();
        lvl = level_of_cfg(4'(c), x[0]);
        minl = x ? 0 : 1;
        cnt = 0;
        down = 0;
        chk("R1", $sformatf("max width cfg=%0d x1=%0d", c, x), int'(width_o), code_of(lvl));
        chk("R1", "link_down after reenable", int'(link_down_o), 0);
        for (int a = 0; a < 4 * LIMIT + 2; a++) begin
          bit stepped;
          stepped = 0;
          pulse(1'b0, 1'b1);
          if (!down) begin
            cnt++;
            if (cnt == LIMIT) begin
              cnt = 0;
              if (lvl > minl) begin lvl--; stepped = 1; end
              else down = 1;
            end
          end
          if (stepped)
            chk(lvl == 0 ? "R5" : "R4", "step width", int'(width_o), code_of(lvl));
          else
            chk(down ? "R6" : "R2", "held width", int'(width_o), code_of(lvl));
          chk(down ? "R6" : "R4", "retrain pulse", int'(retrain_o), stepped ? 1 : 0);
          chk("R6", "link_down", int'(link_down_o), down ? 1 : 0);
          tick();
          chk("R4", "retrain ends", int'(retrain_o), 0);
        end
      end
    end

    // Success clears the run of failures.
    cfg_max_width = 4'b1000; cfg_x1_en = 1'b1;
    do_reenable();
    pulse(1'b0, 1'b1); pulse(1'b0, 1'b1); pulse(1'b1, 1'b0);
    pulse(1'b0, 1'b1); pulse(1'b0, 1'b1);
    chk("R3", "ok clears count", int'(width_o), 8);
    pulse(1'b0, 1'b1);
    chk("R3", "third fail after clear steps", int'(width_o), 4);

    // Simultaneous ok+fail counts as success.
    do_reenable();
    pulse(1'b0, 1'b1); pulse(1'b0, 1'b1); pulse(1'b1, 1'b1);
    pulse(1'b0, 1'b1);
    chk("R3", "ok+fail treated as success", int'(width_o), 8);
    chk("R3", "no retrain", int'(retrain_o), 0);

    // Reenable wins over a same-cycle failure that would otherwise step.
    do_reenable();
    pulse(1'b0, 1'b1); pulse(1'b0, 1'b1);
    train_fail = 1'b1; reenable = 1'b1;
    tick();
    train_fail = 1'b0; reenable = 1'b0;
    chk("R7", "reenable priority width", int'(width_o), 8);
    chk("R7", "reenable priority retrain", int'(retrain_o), 0);
    pulse(1'b0, 1'b1); pulse(1'b0, 1'b1);
    chk("R7", "count restarted by reenable", int'(width_o), 8);

    // Link-down ignores success and is cleared by reenable.
    cfg_max_width = 4'b0010; cfg_x1_en = 1'b0;
    do_reenable();
    for (int i = 0; i < LIMIT; i++) pulse(1'b0, 1'b1);
    chk("R6", "down at x2", int'(link_down_o), 1);
    pulse(1'b1, 1'b0);
    chk("R6", "ok ignored while down", int'(link_down_o), 1);
    chk("R8", "width still onehot x2", int'(width_o), 2);
    cfg_max_width = 4'b0100;
    do_reenable();
    chk("R1", "reenable clears down", int'(link_down_o), 0);
    chk("R1", "reenable width x4", int'(width_o), 4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule